// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

One DMA channel engine. Software programs a source address, a destination address, a unit count and a control word. The engine then moves data unit by unit over a request/acknowledge bus master port. Each beat reads the source and then writes the captured data to the destination.

A unit can be triggered in three ways:
- by an active-low request pin, sensed either by level or by falling edge;
- by an active-low strobe from an on-chip peripheral, always sensed by falling edge;
- by auto-request, which needs no trigger.

When the count runs out, the engine sets a transfer-end flag and, if enabled, raises an interrupt. In cycle-steal mode the bus is handed back after every unit. In burst mode it is held until the count is exhausted.

Registers are selected by `reg_sel`:
- 0: control
- 1: source address
- 2: destination address
- 3: count

The control word layout is:
- bit 0: enable
- bit 1: end flag
- bit 2: interrupt enable
- bits 4:3: size
- bit 5: burst
- bit 6: edge sense
- bits 8:7: source (00 pin, 01 peripheral, 1x auto)
- bit 9: reserved

Top module: `dma_unit_seq`

## Requirements
- R1: After reset, `bus_req` and `irq` are 0 and all four registers read 0.
- R2: Control bit 9 is reserved. It reads 0 whatever value is written to it.
- R3: The edge-sense bit (control bit 6) is writable when parameter CH_INDEX is 0 or 1. For any other CH_INDEX, writes to it are ignored and it reads 0. Software cannot set the end flag (bit 1) by writing 1.
- R4: With source 00 and bit 6 = 0, a low level on `dreq_n`, after two synchronizing flops, starts a unit. If the pin is still low when a unit ends, the next unit starts with `bus_req` low for exactly one cycle in between.
- R5: With source 00 and bit 6 = 1, each falling edge of the synchronized `dreq_n` starts one unit. One edge arriving during an active unit is held pending and runs afterwards.
- R6: With source 01, each falling edge of `periph_req_n` starts exactly one unit, regardless of bit 6. Holding the strobe low starts no further units.
- R7: With source 1x, units start with no external request.
- R8: With bit 5 = 0, `bus_req` drops after every unit. With bit 5 = 1, `bus_req` stays high from the first beat until the last unit ends.
- R9: `bus_size` reports the size field:
  - 00: 1 byte
  - 01: 2 bytes
  - 10: 4 bytes
  - 11: a 16-byte unit made of four 4-byte beats

  Addresses advance by the beat size (1, 2, 4, 4) after each beat. The count drops by one per unit.
- R10: Each beat is a read at the source address (`bus_we` = 0) followed by a write at the destination address (`bus_we` = 1) carrying the data read. Address and control stay stable while `bus_ack` is low.
- R11: When the count reaches 0, the end flag is set. `irq` equals the end flag AND interrupt enable, so with enable 0 the flag still sets but `irq` stays 0.
- R12: Units start only while enable is 1, the end flag is 0 and the count is nonzero. Writing 0 to bit 1 clears the flag and drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_sel) |
| dreq_n | input | 1 | External active-low request pin |
| periph_req_n | input | 1 | On-chip peripheral active-low request strobe |
| bus_req | output | 1 | Bus beat request |
| bus_ack | input | 1 | Beat completes in a cycle where bus_req and bus_ack are both high |
| bus_addr | output | AW | Beat address |
| bus_size | output | 2 | Beat size code |
| bus_we | output | 1 | 1 for a write beat |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, captured on read acknowledge |
| irq | output | 1 | Transfer-end interrupt |

## Verification
Request-to-beat latency depends on the trigger:
- A pin change reaches `bus_req` on the third rising edge after it: two synchronizer flops, then the state register.
- A peripheral strobe or an auto request reaches `bus_req` on the edge after the request is seen.

A beat's address and data change on the edge that samples `bus_ack`. The end flag and `irq` rise on the edge that completes the last write.

The bench steps a behavioural model on the same rising edge as the design, with identical inputs. It compares every output on the following falling edge, so each result is checked in the cycle it is due. Unit counts after the pin and strobe scenarios are also checked against hand-computed values.

// File: rtl/dma_unit_seq.sv
module dma_unit_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int CH_INDEX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          dreq_n,
  input  logic          periph_req_n,
  output logic          bus_req,
  input  logic          bus_ack,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam bit EDGE_OK = (CH_INDEX < 2);
  localparam logic [1:0] SRC_PIN = 2'd0, SRC_PER = 2'd1;

  typedef enum logic [1:0] {IDLE, RD, WR} st_t;
  st_t st;

  logic en, te, ie, burst, edge_sel, pend;
  logic [1:0] size, src;
  logic [AW-1:0] sa, da;
  logic [CW-1:0] cnt;
  logic [1:0] beat;
  logic [DW-1:0] dbuf;
  logic s1, s2, s3, pp;

  wire edge_mode = (src == SRC_PER) || (src == SRC_PIN && edge_sel);
  wire ev        = (src == SRC_PER) ? (pp & ~periph_req_n) : (s3 & ~s2);
  wire want      = src[1] ? 1'b1 : (edge_mode ? (pend | ev) : ~s2);
  wire run       = en && !te && (cnt != '0);
  wire start     = (st == IDLE) && run && want;
  wire last_beat = (size != 2'b11) || (beat == 2'd3);
  wire [AW-1:0] step = (size == 2'b00) ? AW'(1) : (size == 2'b01) ? AW'(2) : AW'(4);

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {22'd0, 1'b0, src, edge_sel, burst, size, ie, te, en};
      2'd1:    reg_rdata = 32'(sa);
      2'd2:    reg_rdata = 32'(da);
      default: reg_rdata = 32'(cnt);
    endcase
  end

  assign bus_req   = (st != IDLE);
  assign bus_we    = (st == WR);
  assign bus_addr  = (st == WR) ? da : sa;
  assign bus_size  = size;
  assign bus_wdata = dbuf;
  assign irq       = te & ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, s2, s3, pp} <= 4'hF;
      pend <= 1'b0;
    end else begin
      s1 <= dreq_n;
      s2 <= s1;
      s3 <= s2;
      pp <= periph_req_n;
      if (!edge_mode) pend <= 1'b0;
      else if (start) pend <= pend & ev;
      else pend <= pend | ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, te, ie, burst, edge_sel} <= '0;
      size <= '0; src <= '0;
      sa <= '0; da <= '0; cnt <= '0;
      st <= IDLE; beat <= '0; dbuf <= '0;
    end else begin
      if (reg_we) begin
        case (reg_sel)
          2'd0: begin
            en       <= reg_wdata[0];
            te       <= te & reg_wdata[1];
            ie       <= reg_wdata[2];
            size     <= reg_wdata[4:3];
            burst    <= reg_wdata[5];
            edge_sel <= EDGE_OK & reg_wdata[6];
            src      <= reg_wdata[8:7];
          end
          2'd1:    sa  <= reg_wdata[AW-1:0];
          2'd2:    da  <= reg_wdata[AW-1:0];
          default: cnt <= reg_wdata[CW-1:0];
        endcase
      end
      case (st)
        IDLE: if (start) begin
          st   <= RD;
          beat <= '0;
        end
        RD: if (bus_ack) begin
          dbuf <= bus_rdata;
          sa   <= sa + step;
          st   <= WR;
        end
        WR: if (bus_ack) begin
          da <= da + step;
          if (!last_beat) begin
            beat <= beat + 2'd1;
            st   <= RD;
          end else begin
            beat <= '0;
            cnt  <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
              te <= 1'b1;
              st <= IDLE;
            end else if (burst && en) st <= RD;
            else st <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r10_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
  a_r11_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_ack && last_beat && cnt == CW'(1)) |=> (te && !bus_req));
  a_r8_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_ack && last_beat && !burst) |=> !bus_req);
  a_r9_block_beats: assert property (@(posedge clk) disable iff (!rst_n)
    (beat != 2'd0) |-> (bus_size == 2'b11 && bus_req));
  a_r12_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (te && !bus_req && !reg_we) |=> !bus_req);
endmodule

// File: tb/sim_dma_unit_seq.sv
module sim_dma_unit_seq;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic reg_we = 0, we1 = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, rdata0, rdata1;
  logic dreq_n = 1, periph_n = 1, ack = 0;
  logic bus_req, bus_we, irq, req1, we1o, irq1;
  logic [1:0] bus_size, size1;
  logic [31:0] bus_addr, bus_wdata, bus_rdata, addr1, wdata1;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction
  assign bus_rdata = pat(bus_addr);

  dma_unit_seq u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rdata0), .dreq_n(dreq_n), .periph_req_n(periph_n),
    .bus_req(bus_req), .bus_ack(ack), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));
  dma_unit_seq #(.CH_INDEX(2)) u1 (.clk(clk), .rst_n(rst_n), .reg_we(we1), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rdata1), .dreq_n(1'b1), .periph_req_n(1'b1),
    .bus_req(req1), .bus_ack(1'b0), .bus_addr(addr1), .bus_size(size1),
    .bus_we(we1o), .bus_wdata(wdata1), .bus_rdata(32'd0), .irq(irq1));

  int vecs = 0, errs = 0, cyc = 0;
  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  bit m_en, m_te, m_ie, m_burst, m_edge, m_pend, m_s1 = 1, m_s2 = 1, m_s3 = 1, m_pp = 1;
  int m_size, m_src, m_cnt, m_st, m_beat;
  logic [31:0] m_sa, m_da, m_buf;
  always @(posedge clk) begin
    if (!rst_n) begin
      {m_en, m_te, m_ie, m_burst, m_edge, m_pend} = 0;
      {m_s1, m_s2, m_s3, m_pp} = 4'hF;
      m_size = 0; m_src = 0; m_cnt = 0; m_st = 0; m_beat = 0;
      m_sa = 0; m_da = 0; m_buf = 0;
    end else begin
      bit em, ev, rq, go, lastb;
      int step;
      em = (m_src == 1) || (m_src == 0 && m_edge);
      ev = (m_src == 1) ? (m_pp && !periph_n) : (m_s3 && !m_s2);
      rq = (m_src >= 2) ? 1 : em ? (m_pend || ev) : !m_s2;
      go = (m_st == 0) && m_en && !m_te && m_cnt != 0 && rq;
      step = (m_size == 0) ? 1 : (m_size == 1) ? 2 : 4;
      lastb = (m_size != 3) || (m_beat == 3);
      if (!em) m_pend = 0; else if (go) m_pend = m_pend && ev; else m_pend = m_pend || ev;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = dreq_n; m_pp = periph_n;
      if (reg_we) case (reg_sel)
        0: begin
          m_en = reg_wdata[0]; m_te = m_te && reg_wdata[1]; m_ie = reg_wdata[2];
          m_size = reg_wdata[4:3]; m_burst = reg_wdata[5]; m_edge = reg_wdata[6];
          m_src = reg_wdata[8:7];
        end
        1: m_sa = reg_wdata;
        2: m_da = reg_wdata;
        default: m_cnt = reg_wdata[15:0];
      endcase
      if (m_st == 0) begin
        if (go) begin m_st = 1; m_beat = 0; end
      end else if (m_st == 1) begin
        if (ack) begin m_buf = pat(m_sa); m_sa += step; m_st = 2; end
      end else if (ack) begin
        m_da += step;
        if (!lastb) begin m_beat++; m_st = 1; end
        else begin
          m_beat = 0;
          if (m_cnt == 1) begin m_te = 1; m_st = 0; end
          else m_st = (m_burst && m_en) ? 1 : 0;
          m_cnt = (m_cnt - 1) & 16'hFFFF;
        end
      end
    end
  end

  // compare each cycle, then the bus slave acknowledges
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R8 bus_req", {31'd0, bus_req}, {31'd0, m_st != 0});
      chk("R11 irq", {31'd0, irq}, {31'd0, m_te && m_ie});
      if (m_st != 0) begin
        chk("R9 bus_addr", bus_addr, (m_st == 2) ? m_da : m_sa);
        chk("R9 bus_size", {30'd0, bus_size}, m_size[31:0]);
        chk("R10 bus_we", {31'd0, bus_we}, {31'd0, m_st == 2});
        if (m_st == 2) chk("R10 bus_wdata", bus_wdata, m_buf);
      end
    end
    ack = bus_req && !ack;
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); reg_sel = s; #1 v = rdata0;
  endtask
  task automatic wait_idle();
    int n = 0;
    while ((bus_req || !m_te) && n < 2000) begin @(negedge clk); n++; end
  endtask
  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(3, v); chk("R1 count", v, 0);
    chk("R1 idle", {30'd0, bus_req, irq}, 0);

    wr(0, 32'h3FF); rd(0, v); chk("R2 reserved bit", v, 32'h1FD);
    @(negedge clk); we1 = 1; reg_sel = 0; reg_wdata = 32'h3FF;
    @(negedge clk); we1 = 0; #1 chk("R3 sense bit channel 2", rdata1, 32'h1BD);
    wr(0, 0);

    // R7 auto, cycle steal, byte
    wr(1, 32'h100); wr(2, 32'h200); wr(3, 3); wr(0, 32'h105);
    wait_idle(); settle(2);
    rd(3, v); chk("R7 auto count done", v, 0);
    rd(0, v); chk("R11 end flag set", v[1], 1);
    chk("R11 irq raised", {31'd0, irq}, 1);
    wr(0, 32'h105); rd(0, v); chk("R12 flag cleared", v[1], 0);
    chk("R12 irq dropped", {31'd0, irq}, 0);

    // R9 burst, 16-byte units, ie off
    wr(0, 0); wr(1, 32'h1000); wr(2, 32'h2000); wr(3, 2); wr(0, 32'h139);
    wait_idle(); settle(2);
    rd(1, v); chk("R9 source advance", v, 32'h1020);
    rd(2, v); chk("R9 dest advance", v, 32'h2020);
    chk("R11 no irq when disabled", {31'd0, irq}, 0);
    wr(0, 0);

    // R4 level sense, word units
    wr(1, 32'h40); wr(2, 32'h80); wr(3, 10); wr(0, 32'h9);
    dreq_n = 0; settle(20); dreq_n = 1; settle(20);
    rd(3, v); chk("R4 level units", v, m_cnt[31:0]);
    chk("R4 some units ran", {31'd0, v < 10}, 1);
    wr(0, 0);

    // R5 edge sense with one edge during an active unit
    wr(3, 5); wr(0, 32'h41);
    dreq_n = 0; settle(2); dreq_n = 1; settle(2); dreq_n = 0; settle(2); dreq_n = 1;
    settle(30);
    rd(3, v); chk("R5 two edges two units", v, 3);
    wr(0, 0);

    // R6 peripheral strobe, edge forced
    wr(3, 4); wr(0, 32'h81);
    periph_n = 0; settle(30);
    rd(3, v); chk("R6 held strobe one unit", v, 3);
    periph_n = 1; settle(2); periph_n = 0; settle(20); periph_n = 1;
    rd(3, v); chk("R6 second strobe", v, 2);
    wr(0, 0); settle(4);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule